// File: doc/BRIEF.md
# Single-Precision to 8-bit Float (4-bit Exponent, 3-bit Mantissa) Scale Encoder

This block turns a non-negative IEEE-754 single-precision number into an 8-bit floating-point code. The code has a 4-bit exponent with bias 7 and a 3-bit mantissa. It is meant for block scale factors that are computed in full precision and stored compactly. The exponent and fraction are read straight from the source fields. The mantissa is rounded to nearest with ties to even, using the discarded fraction bits as round and sticky information. When rounding overflows the mantissa, the carry moves into the exponent.

The largest finite code stands for 448.0. Any input at or above that value saturates to it, and so does an infinity or NaN input. Very small inputs take a separate subnormal path: the value times 512 is rounded to nearest-even and then clamped to 0..7. Negative inputs, zero and single-precision denormals all give the all-zero code.

The result is registered. `out_valid` is `in_valid` delayed by one clock. `out_code` keeps its last value in cycles where no input is presented.

Top module: `fp32_to_e4m3`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock, and the code for a word presented with `in_valid` high appears on `out_code` in the following cycle.
- R2: While `rst_n` is low, and in the first cycle after its release, `out_valid` is 0 and `out_code` is 0x00.
- R3: An input with the sign bit set, an exponent field of 0 (zero or denormal), or a magnitude below 2^-10 encodes as 0x00. Exactly 2^-10 also encodes as 0x00, because 0.5 rounds to the even value 0.
- R4: An input of 448.0 or more, or an exponent field of all ones (infinity or NaN), encodes as 0x7E: exponent field 15, mantissa 6.
- R5: For 2^-6 <= value < 448, `out_code[6:3]` is floor(log2(value)) + 7. `out_code[2:0]` is the top three fraction bits rounded to nearest with ties to even. The round bit is fraction bit 19 and the sticky bit is the OR of fraction bits 18..0.
- R6: When mantissa rounding reaches 8, the exponent field increases by one and the mantissa becomes 0. For example, 1.9375 gives 0x40 and 248.0 gives 0x78.
- R7: For 2^-10 < value < 2^-6, the exponent field is 0 and `out_code[2:0]` is value x 512 rounded to nearest-even and clamped to 7. For example, 1.9375 x 2^-7 gives 0x07.
- R8: While `in_valid` is low, `out_code` keeps its previous value, whatever is on `in_word`.
- R9: A valid output never has bit 7 set and is never 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_word` as a value to encode |
| in_word | input | 32 | Single-precision input value |
| out_valid | output | 1 | Marks `out_code` as freshly encoded |
| out_code | output | 8 | Encoded 8-bit float: bit 7 is 0, bits 6:3 are the exponent, bits 2:0 are the mantissa |

## Verification
The bound checker checks the behaviours that follow from input fields alone, on every cycle. These are the one-cycle valid delay, holding the code while idle, the zero code for negative and zero-exponent words, and saturation for all-ones and oversized exponents. It also checks that subnormal-range inputs give a zero exponent field, and that the code never leaves the legal range. Rounding itself can only be shown by the bench's chosen values. These cover ties that round down and ties that round up, values just above a tie, the carry into the exponent, the subnormal clamp at 7, and the boundaries at 2^-10, 2^-6 and 448.

// File: rtl/e4m3_enc_pkg.sv
package e4m3_enc_pkg;
    // source format
    localparam int SRC_EXP_W  = 8;
    localparam int SRC_FRAC_W = 23;
    localparam int SRC_W      = 1 + SRC_EXP_W + SRC_FRAC_W;
    localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int SIG_W      = SRC_FRAC_W + 1;

    // destination format
    localparam int DST_EXP_W  = 4;
    localparam int DST_MAN_W  = 3;
    localparam int DST_W      = 1 + DST_EXP_W + DST_MAN_W;
    localparam int DST_BIAS   = 7;
    localparam int DST_EMAX   = (1 << DST_EXP_W) - 1 - DST_BIAS;
    localparam int DST_EMIN   = 1 - DST_BIAS;
    localparam int SAT_MAN    = (1 << DST_MAN_W) - 2;
    localparam int SUB_LOG2   = DST_BIAS - 1 + DST_MAN_W;
    localparam int SUB_LOWEST = -(SUB_LOG2 + 1);

    // derived widths and constants
    localparam int NORM_SHIFT = SRC_FRAC_W - DST_MAN_W;
    localparam int RND_W      = DST_MAN_W + 2;
    localparam int SH_W       = $clog2(SIG_W + 1);
    localparam int UE_W       = SRC_EXP_W + 2;

    localparam logic [SRC_FRAC_W-1:0] SAT_FRAC =
        SRC_FRAC_W'(SAT_MAN) << NORM_SHIFT;
    localparam logic [DST_W-1:0] SAT_CODE =
        {1'b0, {DST_EXP_W{1'b1}}, DST_MAN_W'(SAT_MAN)};

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_SAT,
        CLS_NORM,
        CLS_SUB
    } cls_e;

    typedef struct packed {
        logic             vld;
        logic [DST_W-1:0] code;
    } enc_state_t;
endpackage

// File: rtl/fp32_classify.sv
module fp32_classify
    import e4m3_enc_pkg::*;
(
    input  logic [SRC_W-1:0]       word,
    output cls_e                   cls,
    output logic signed [UE_W-1:0] unb_exp,
    output logic [SIG_W-1:0]       sig
);
    logic                  sgn;
    logic [SRC_EXP_W-1:0]  efld;
    logic [SRC_FRAC_W-1:0] frac;
    int                    ue_i;

    assign sgn  = word[SRC_W-1];
    assign efld = word[SRC_W-2 -: SRC_EXP_W];
    assign frac = word[SRC_FRAC_W-1:0];

    always_comb begin
        ue_i    = int'(efld) - SRC_BIAS;
        unb_exp = UE_W'(ue_i);
        sig     = {1'b1, frac};
        if (sgn || efld == '0) begin
            cls = CLS_ZERO;
        end else if (efld == '1) begin
            cls = CLS_SAT;
        end else if (ue_i > DST_EMAX) begin
            cls = CLS_SAT;
        end else if (ue_i == DST_EMAX && frac >= SAT_FRAC) begin
            cls = CLS_SAT;
        end else if (ue_i >= DST_EMIN) begin
            cls = CLS_NORM;
        end else if (ue_i >= SUB_LOWEST) begin
            cls = CLS_SUB;
        end else begin
            cls = CLS_ZERO;
        end
    end
endmodule

// File: rtl/rne_rshift.sv
module rne_rshift #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 5,
    parameter int SH_W  = 5
) (
    input  logic [IN_W-1:0]  val,
    input  logic [SH_W-1:0]  sh,
    output logic [OUT_W-1:0] res
);
    logic [OUT_W-1:0] trunc;
    logic             rbit;
    logic             sticky;
    logic             inc;

    always_comb begin
        trunc  = OUT_W'(val >> sh);
        rbit   = 1'b0;
        sticky = 1'b0;
        for (int i = 0; i < IN_W; i++) begin
            if (i == int'(sh) - 1) rbit = val[i];
            if (i < int'(sh) - 1)  sticky = sticky | val[i];
        end
        inc = rbit & (sticky | trunc[0]);
        res = trunc + OUT_W'(inc);
    end
endmodule

// File: rtl/fp32_to_e4m3.sv
module fp32_to_e4m3
    import e4m3_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_word,
    output logic             out_valid,
    output logic [DST_W-1:0] out_code
);
    localparam logic [RND_W-1:0] MAN_WRAP = RND_W'(1 << (DST_MAN_W + 1));
    localparam logic [RND_W-1:0] SUB_CAP  = RND_W'((1 << DST_MAN_W) - 1);

    cls_e                   cls;
    logic signed [UE_W-1:0] unb_exp;
    logic [SIG_W-1:0]       sig;
    logic [SH_W-1:0]        sub_sh;
    logic [RND_W-1:0]       norm_q;
    logic [RND_W-1:0]       sub_q;
    int                     ue_i;
    enc_state_t             state_d, state_q;
    logic [DST_W-1:0]       enc_code;
    logic [DST_EXP_W-1:0]   bexp;
    logic [DST_MAN_W-1:0]   man;

    fp32_classify u_classify (
        .word    (in_word),
        .cls     (cls),
        .unb_exp (unb_exp),
        .sig     (sig)
    );

    assign ue_i   = int'(unb_exp);
    assign sub_sh = SH_W'(SRC_FRAC_W - SUB_LOG2 - ue_i);

    rne_rshift #(.IN_W(SIG_W), .OUT_W(RND_W), .SH_W(SH_W)) u_rnd_norm (
        .val (sig),
        .sh  (SH_W'(NORM_SHIFT)),
        .res (norm_q)
    );

    rne_rshift #(.IN_W(SIG_W), .OUT_W(RND_W), .SH_W(SH_W)) u_rnd_sub (
        .val (sig),
        .sh  (sub_sh),
        .res (sub_q)
    );

    always_comb begin
        bexp = DST_EXP_W'(ue_i + DST_BIAS);
        man  = norm_q[DST_MAN_W-1:0];
        unique case (cls)
            CLS_SAT:  enc_code = SAT_CODE;
            CLS_NORM: begin
                if (norm_q == MAN_WRAP) begin
                    bexp = bexp + DST_EXP_W'(1);
                    man  = '0;
                end
                enc_code = {1'b0, bexp, man};
            end
            CLS_SUB: begin
                man = (sub_q > SUB_CAP) ? SUB_CAP[DST_MAN_W-1:0]
                                        : sub_q[DST_MAN_W-1:0];
                enc_code = {1'b0, {DST_EXP_W{1'b0}}, man};
            end
            default:  enc_code = '0;
        endcase

        state_d.vld  = in_valid;
        state_d.code = in_valid ? enc_code : state_q.code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign out_code  = state_q.code;
endmodule

// File: rtl/fp32_to_e4m3_chk.sv
module fp32_to_e4m3_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic [7:0]  out_code
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code)); // R8
    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_word[31] || in_word[30:23] == 8'h00)) |=> out_code == 8'h00); // R3
    AST_SPECIAL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_word[31] && in_word[30:23] == 8'hFF) |=> out_code == 8'h7E); // R4
    AST_BIG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_word[31] && in_word[30:23] > 8'd135) |=> out_code == 8'h7E); // R4
    AST_SUB_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_word[31] && in_word[30:23] >= 8'd117 && in_word[30:23] <= 8'd120)
        |=> out_code[6:3] == 4'h0); // R7
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_code[7] && out_code != 8'h7F)); // R9
endmodule

bind fp32_to_e4m3 fp32_to_e4m3_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/fp32_to_e4m3_bench.sv
module fp32_to_e4m3_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [7:0]  out_code;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fp32_to_e4m3 u_fp32_to_e4m3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    typedef struct packed {
        logic [31:0] w;
        logic [7:0]  code;
        logic [15:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 8'h00, "R3"},  // +0
        '{32'hBF800000, 8'h00, "R3"},  // -1.0
        '{32'h80000000, 8'h00, "R3"},  // -0
        '{32'h00400000, 8'h00, "R3"},  // source denormal
        '{32'h3A000000, 8'h00, "R3"},  // 2^-11
        '{32'h3A800000, 8'h00, "R3"},  // 2^-10, tie to 0
        '{32'h3F800000, 8'h38, "R5"},  // 1.0
        '{32'h3FC00000, 8'h3C, "R5"},  // 1.5
        '{32'h40400000, 8'h44, "R5"},  // 3.0
        '{32'h3E99999A, 8'h2A, "R5"},  // 0.3
        '{32'h3F880000, 8'h38, "R5"},  // 1.0625 tie stays even
        '{32'h3F980000, 8'h3A, "R5"},  // 1.1875 tie goes up to even
        '{32'h3F880001, 8'h39, "R5"},  // just above tie
        '{32'h3C800000, 8'h08, "R5"},  // 2^-6 smallest normal
        '{32'h43800000, 8'h78, "R5"},  // 256
        '{32'h43D00000, 8'h7D, "R5"},  // 416
        '{32'h3FF80000, 8'h40, "R6"},  // 1.9375 carries
        '{32'h43780000, 8'h78, "R6"},  // 248 carries to top exponent
        '{32'h43E00000, 8'h7E, "R4"},  // 448
        '{32'h43DC0000, 8'h7E, "R4"},  // 440 rounds to max
        '{32'h43FA0000, 8'h7E, "R4"},  // 500
        '{32'h501502F9, 8'h7E, "R4"},  // 1e10
        '{32'h7F800000, 8'h7E, "R4"},  // +inf
        '{32'h7FC00000, 8'h7E, "R4"},  // NaN
        '{32'h3B000000, 8'h01, "R7"},  // 2^-9
        '{32'h3C000000, 8'h04, "R7"},  // 2^-7
        '{32'h3BC00000, 8'h03, "R7"},  // 3 x 2^-9
        '{32'h3AC00000, 8'h01, "R7"},  // 0.75 x 2^-9
        '{32'h3BA00000, 8'h02, "R7"},  // 2.5 tie to 2
        '{32'h3BE00000, 8'h04, "R7"},  // 3.5 tie to 4
        '{32'h3C780000, 8'h07, "R7"}   // 7.75 clamps to 7
    };

    task automatic check(input logic [15:0] req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2", 32'(out_valid), 32'd0);
        check("R2", 32'(out_code), 32'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", 32'(out_valid), 32'd0);
        check("R2", 32'(out_code), 32'h00);

        // back-to-back table walk; each code lands one cycle later (R1)
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_word  = VECS[i].w;
            @(negedge clk);
            check("R1", 32'(out_valid), 32'd1);
            check(VECS[i].req, 32'(out_code), 32'(VECS[i].code));
            check("R9", 32'(out_code[7]), 32'd0);
        end

        // idle cycles: code holds, valid drops (R8, R1)
        in_valid = 1'b1;
        in_word  = 32'h3FC00000;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'h43E00000;
        @(negedge clk);
        check("R1", 32'(out_valid), 32'd0);
        check("R8", 32'(out_code), 32'h3C);
        in_word = 32'h00000000;
        @(negedge clk);
        check("R8", 32'(out_code), 32'h3C);

        // single pulse after idle
        in_valid = 1'b1;
        in_word  = 32'h40400000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", 32'(out_valid), 32'd1);
        check("R5", 32'(out_code), 32'h44);
        @(negedge clk);
        check("R1", 32'(out_valid), 32'd0);

        // reset mid-run clears state
        in_valid = 1'b1;
        in_word  = 32'h43E00000;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R2", 32'(out_valid), 32'd0);
        check("R2", 32'(out_code), 32'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4", 32'(out_code), 32'h7E);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule